// File: doc/BRIEF.md
# YCbCr 4:2:2 Pixel Port Formatter

The formatter takes 4:2:2 video one pixel pair at a time: two luma samples and the Cb and Cr samples they share. It places these samples on a 16-bit output port made of two byte lanes. It also drives a pixel clock output and one output-enable per lane. Each pair fills a group of four slots, and each slot lasts one cycle of the block clock.

In the narrow layout, chroma and luma bytes are interleaved on the lower lane at the full slot rate, and the upper lane is disabled. In the wide layout, luma goes on the upper lane and chroma on the lower lane. Each 16-bit word is held for two slots, so the word rate is half the slot rate.

A swap bit reverses the chroma order inside each pair. A clock-select field picks a full-rate or half-rate pixel clock, and an invert bit flips the clock polarity. All of these settings take effect only when a pair that carries the start-of-line marker is accepted. As a result, no line is ever emitted in a mixed format.

Top module: `yc_port_fmt`

## Requirements
- R1: After reset, the block uses the narrow layout, no swap, the full-rate clock and no inversion. It holds no pair, so `in_ready` is 0, `port_oe` is 2'b01, `port_d` is 16'h0080 and `port_clk` is 0.
- R2: `in_ready` is high for exactly one cycle in every four. A pair is accepted when `in_valid` and `in_ready` are both high, and the pair occupies the four cycles that follow, called slots 0 to 3.
- R3: With format code 4'b0011 (narrow), the lower lane carries Cb, Y0, Cr, Y1 in slots 0 to 3. `port_oe` is 2'b01 and the upper lane reads 0.
- R4: With format code 4'b0010 (wide), `port_d` is {Y0, Cb} in slots 0 and 1 and {Y1, Cr} in slots 2 and 3. `port_oe` is 2'b11.
- R5: When the swap bit is 1, Cr takes the place of Cb and Cb takes the place of Cr in both layouts. The luma order does not change.
- R6: With clock code 3'b000 and no inversion, `port_clk` is 1 in slots 1 and 3 and 0 in slots 0 and 2. This gives a rising edge at each narrow-layout luma byte and a falling edge at each chroma byte.
- R7: With clock code 3'b101 and no inversion, `port_clk` is 0 in slots 0 and 1 and 1 in slots 2 and 3.
- R8: When the invert bit is 1, `port_clk` is the complement of the value given in R6 or R7.
- R9: A reserved format code (4'b0000, 4'b0001, or 4'b0100 to 4'b1111) given at a line start leaves the previous layout in force.
- R10: A reserved clock code (any code other than 3'b000 and 3'b101) given at a line start leaves the previous clock rate in force.
- R11: Format, swap, clock and invert inputs are sampled only when a pair with `in_sol` = 1 is accepted. Changes at other times have no effect.
- R12: In a four-slot group where no pair was accepted, blanking values are output: luma slots carry 8'h10 and chroma slots carry 8'h80, placed in the current layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 4 | Output layout code |
| cfg_cswap | input | 1 | Chroma order swap |
| cfg_cksel | input | 3 | Pixel clock rate code |
| cfg_ckinv | input | 1 | Pixel clock polarity invert |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Pair can be accepted this cycle |
| in_sol | input | 1 | Pair is the first of a line |
| in_y0 | input | 8 | First luma sample |
| in_y1 | input | 8 | Second luma sample |
| in_cb | input | 8 | Cb sample of the pair |
| in_cr | input | 8 | Cr sample of the pair |
| port_d | output | 16 | Output data, upper and lower byte lanes |
| port_oe | output | 2 | Lane enables, bit 1 for the upper lane, bit 0 for the lower lane |
| port_clk | output | 1 | Pixel clock output |

## Verification
Some rules are checked by the assertions on every cycle:
- `in_ready` never stays high for two cycles in a row.
- Only the two legal lane-enable codes ever appear.
- A disabled upper lane reads zero.
- In the wide layout, each word holds still across its two slots.
- The pixel clock is high (low when inverted) in the cycle where a new pair can be accepted.

The following are shown only by the bench's sweeps:
- The exact byte order for every combination of layout, swap, rate and polarity.
- Holding the previous setting when a reserved code is given.
- Ignoring setting changes in the middle of a line.
- Blanking values in groups with no pair.

// File: rtl/yc_fmt_pkg.sv
package yc_fmt_pkg;
    localparam int LANE_W  = 8;
    localparam int SLOT_W  = 2;
    localparam int FMT_W   = 4;
    localparam int CKS_W   = 3;

    localparam logic [FMT_W-1:0]  FMT_WIDE   = 4'b0010;
    localparam logic [FMT_W-1:0]  FMT_NARROW = 4'b0011;
    localparam logic [CKS_W-1:0]  CKS_FULL   = 3'b000;
    localparam logic [CKS_W-1:0]  CKS_HALF   = 3'b101;
    localparam logic [LANE_W-1:0] BLANK_Y    = 8'h10;
    localparam logic [LANE_W-1:0] BLANK_C    = 8'h80;
    localparam logic [SLOT_W-1:0] SLOT_LAST  = '1;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic wide;
        logic cswap;
        logic half;
        logic inv;
    } cfg_t;

    typedef struct packed {
        lane_t y0;
        lane_t y1;
        lane_t cb;
        lane_t cr;
    } pair_t;
endpackage

// File: rtl/yc_fmt_cfg.sv
module yc_fmt_cfg
    import yc_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [FMT_W-1:0] fmt_code,
    input  logic             cswap,
    input  logic [CKS_W-1:0] cks_code,
    input  logic             ckinv,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.cswap = cswap;
            cfg_d.inv   = ckinv;
            case (fmt_code)
                FMT_WIDE:   cfg_d.wide = 1'b1;
                FMT_NARROW: cfg_d.wide = 1'b0;
                default:    cfg_d.wide = cfg_q.wide;
            endcase
            case (cks_code)
                CKS_FULL: cfg_d.half = 1'b0;
                CKS_HALF: cfg_d.half = 1'b1;
                default:  cfg_d.half = cfg_q.half;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/yc_fmt_mux.sv
module yc_fmt_mux
    import yc_fmt_pkg::*;
(
    input  logic [SLOT_W-1:0]   slot,
    input  logic                have,
    input  pair_t               pair,
    input  cfg_t                cfg,
    output logic [2*LANE_W-1:0] data,
    output logic [1:0]          oe,
    output logic                pclk
);
    lane_t y0, y1, c0, c1, y_sel, c_sel;

    always_comb begin
        y0 = have ? pair.y0 : BLANK_Y;
        y1 = have ? pair.y1 : BLANK_Y;
        c0 = have ? (cfg.cswap ? pair.cr : pair.cb) : BLANK_C;
        c1 = have ? (cfg.cswap ? pair.cb : pair.cr) : BLANK_C;
        y_sel = slot[1] ? y1 : y0;
        c_sel = slot[1] ? c1 : c0;
        if (cfg.wide) begin
            data = {y_sel, c_sel};
            oe   = 2'b11;
        end else begin
            data = {{LANE_W{1'b0}}, (slot[0] ? y_sel : c_sel)};
            oe   = 2'b01;
        end
        pclk = (cfg.half ? slot[1] : slot[0]) ^ cfg.inv;
    end
endmodule

// File: rtl/yc_port_fmt.sv
module yc_port_fmt
    import yc_fmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cfg_fmt,
    input  logic                cfg_cswap,
    input  logic [2:0]          cfg_cksel,
    input  logic                cfg_ckinv,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_sol,
    input  logic [7:0]          in_y0,
    input  logic [7:0]          in_y1,
    input  logic [7:0]          in_cb,
    input  logic [7:0]          in_cr,
    output logic [15:0]         port_d,
    output logic [1:0]          port_oe,
    output logic                port_clk
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              have;
        pair_t             pair;
    } st_t;

    st_t  st_d, st_q;
    cfg_t cfg;
    logic accept;
    logic [SLOT_W-1:0] slot_q;
    logic inv_q;

    assign in_ready = (st_q.slot == SLOT_LAST);
    assign accept   = in_valid && in_ready;
    assign slot_q   = st_q.slot;
    assign inv_q    = cfg.inv;

    always_comb begin
        st_d      = st_q;
        st_d.slot = st_q.slot + 1'b1;
        if (in_ready) begin
            st_d.have = accept;
            if (accept) begin
                st_d.pair.y0 = in_y0;
                st_d.pair.y1 = in_y1;
                st_d.pair.cb = in_cb;
                st_d.pair.cr = in_cr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    yc_fmt_cfg i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && in_sol),
        .fmt_code (cfg_fmt),
        .cswap    (cfg_cswap),
        .cks_code (cfg_cksel),
        .ckinv    (cfg_ckinv),
        .cfg      (cfg)
    );

    yc_fmt_mux i_mux (
        .slot (st_q.slot),
        .have (st_q.have),
        .pair (st_q.pair),
        .cfg  (cfg),
        .data (port_d),
        .oe   (port_oe),
        .pclk (port_clk)
    );
endmodule

// File: rtl/yc_port_fmt_chk.sv
module yc_port_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic [15:0] port_d,
    input logic [1:0]  port_oe,
    input logic        port_clk,
    input logic [1:0]  slot,
    input logic        inv
);
    // R2: acceptance window lasts a single cycle
    a_r2_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R3 / R4: only the two legal lane-enable codes
    a_r3_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe == 2'b01) || (port_oe == 2'b11));

    // R3: disabled upper lane is quiet
    a_r3_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !port_oe[1] |-> (port_d[15:8] == 8'h00));

    // R4: a wide word is held across its two slots
    a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe == 2'b11 && slot[0]) |-> $stable(port_d));

    // R6 / R7 / R8: last slot of a group is the high phase of either rate
    a_r8_clk_last_slot: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (port_clk == !inv));
endmodule

bind yc_port_fmt yc_port_fmt_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .port_d   (port_d),
    .port_oe  (port_oe),
    .port_clk (port_clk),
    .slot     (slot_q),
    .inv      (inv_q)
);

// File: tb/test_yc_port_fmt.sv
module test_yc_port_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = 4'b0011;
    logic        cfg_cswap = 1'b0;
    logic [2:0]  cfg_cksel = 3'b000;
    logic        cfg_ckinv = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sol = 1'b0;
    logic [7:0]  in_y0 = '0, in_y1 = '0, in_cb = '0, in_cr = '0;
    logic [15:0] port_d;
    logic [1:0]  port_oe;
    logic        port_clk;

    int n_vec = 0;
    int n_bad = 0;

    // model of the settings in force
    logic m_wide = 1'b0, m_swap = 1'b0, m_half = 1'b0, m_inv = 1'b0;

    always #2 clk = ~clk;

    yc_port_fmt i_yc_port_fmt (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_load();
        m_swap = cfg_cswap;
        m_inv  = cfg_ckinv;
        if (cfg_fmt == 4'b0010) m_wide = 1'b1;
        else if (cfg_fmt == 4'b0011) m_wide = 1'b0;
        if (cfg_cksel == 3'b000) m_half = 1'b0;
        else if (cfg_cksel == 3'b101) m_half = 1'b1;
    endtask

    task automatic chk_slot(input int s, input logic have,
                            input logic [7:0] y0, y1, cb, cr, input string tag);
        logic [7:0] ey0, ey1, ec0, ec1, ey, ec;
        logic [15:0] ed;
        logic eclk;
        string td, tc;
        ey0 = have ? y0 : 8'h10;
        ey1 = have ? y1 : 8'h10;
        ec0 = have ? (m_swap ? cr : cb) : 8'h80;
        ec1 = have ? (m_swap ? cb : cr) : 8'h80;
        ey  = (s >= 2) ? ey1 : ey0;
        ec  = (s >= 2) ? ec1 : ec0;
        ed  = m_wide ? {ey, ec} : {8'h00, ((s % 2) == 1) ? ey : ec};
        eclk = (m_half ? (s >= 2) : ((s % 2) == 1)) ^ m_inv;
        td = (tag != "") ? tag : (!have ? "R12" : (m_swap ? "R5" : (m_wide ? "R4" : "R3")));
        tc = (tag != "") ? tag : (m_inv ? "R8" : (m_half ? "R7" : "R6"));
        chk({td, " data"}, 32'(port_d), 32'(ed));
        chk({td, " oe"}, 32'(port_oe), m_wide ? 32'd3 : 32'd1);
        chk({tc, " clk"}, 32'(port_clk), 32'(eclk));
    endtask

    task automatic send(input logic [7:0] y0, y1, cb, cr, input logic sol, input string tag);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_sol = sol;
        in_y0 = y0; in_y1 = y1; in_cb = cb; in_cr = cr;
        if (sol) model_load();
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
        for (int s = 0; s < 4; s++) begin
            if (s > 0) @(negedge clk);
            chk_slot(s, 1'b1, y0, y1, cb, cr, tag);
        end
    endtask

    task automatic idle_group();
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            if (s > 0) @(negedge clk);
            chk_slot(s, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, "");
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int rdy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ready", 32'(in_ready), 32'd0);
        chk("R1 oe", 32'(port_oe), 32'd1);
        chk("R1 data", 32'(port_d), 32'h0080);
        chk("R1 clk", 32'(port_clk), 32'd0);

        // R2: one ready cycle in four
        rdy = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rdy += int'(in_ready);
        end
        chk("R2 ready count", 32'(rdy), 32'd4);

        // sweep all valid setting combinations
        for (int k = 0; k < 16; k++) begin
            cfg_fmt   = k[0] ? 4'b0010 : 4'b0011;
            cfg_cswap = k[1];
            cfg_cksel = k[2] ? 3'b101 : 3'b000;
            cfg_ckinv = k[3];
            send(8'(16 + 7*k), 8'(40 + 11*k), 8'(100 + 3*k), 8'(200 - 5*k), 1'b1, "");
            send(8'(90 + k), 8'(150 - k), 8'(60 + 2*k), 8'(230 - 2*k), 1'b0, "");
        end

        // R9: reserved layout codes keep the previous layout
        for (int w = 0; w < 2; w++) begin
            cfg_fmt = w[0] ? 4'b0010 : 4'b0011;
            cfg_cksel = 3'b000; cfg_cswap = 1'b0; cfg_ckinv = 1'b0;
            send(8'h21, 8'h22, 8'h23, 8'h24, 1'b1, "");
            for (int c = 0; c < 16; c++) begin
                if (c == 2 || c == 3) continue;
                cfg_fmt = 4'(c);
                send(8'(c), 8'(c + 32), 8'(c + 64), 8'(c + 96), 1'b1, "R9");
            end
        end

        // R10: reserved clock codes keep the previous rate
        for (int h = 0; h < 2; h++) begin
            cfg_fmt = 4'b0011;
            cfg_cksel = h[0] ? 3'b101 : 3'b000;
            send(8'h31, 8'h32, 8'h33, 8'h34, 1'b1, "");
            for (int c = 0; c < 8; c++) begin
                if (c == 0 || c == 5) continue;
                cfg_cksel = 3'(c);
                send(8'(c + 8), 8'(c + 16), 8'(c + 24), 8'(c + 48), 1'b1, "R10");
            end
        end

        // R11: mid-line changes are ignored until the next line start
        cfg_fmt = 4'b0011; cfg_cswap = 1'b0; cfg_cksel = 3'b000; cfg_ckinv = 1'b0;
        send(8'h41, 8'h42, 8'h43, 8'h44, 1'b1, "");
        cfg_fmt = 4'b0010; cfg_cswap = 1'b1; cfg_cksel = 3'b101; cfg_ckinv = 1'b1;
        send(8'h51, 8'h52, 8'h53, 8'h54, 1'b0, "R11");
        send(8'h61, 8'h62, 8'h63, 8'h64, 1'b0, "R11");
        send(8'h71, 8'h72, 8'h73, 8'h74, 1'b1, "R11");

        // R12: blanking in empty groups, both layouts
        idle_group();
        cfg_fmt = 4'b0011; cfg_cswap = 1'b0; cfg_cksel = 3'b000; cfg_ckinv = 1'b0;
        send(8'h81, 8'h82, 8'h83, 8'h84, 1'b1, "");
        idle_group();
        idle_group();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule